// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It frees the bus after an interrupted transfer, a power loss or a reset has left a slave part-way through a byte and holding the data line low. A start strobe launches a recovery. The sequencer then toggles the clock line and looks at the data line near the end of every clock-high phase. When it finds the data line released, it stops toggling, forms a START condition and hands the bus over to the normal controller.

Both lines are open-drain. Each output of the block is a pull-low enable: 1 pulls the line low and 0 lets the pull-up raise it. The timing of every clock phase comes from a divider value that is captured with the start strobe. If the slave still holds the data line after the pulse budget is used up, the sequencer gives up, leaves both lines released and reports failure.

Top module: `busrec_seq`

## Requirements
- R1: After reset, and whenever no recovery is running, `scl_pull_o`, `sda_pull_o`, `done_o` and `fail_o` are all 0.
- R2: A start strobe in idle captures `div_i`. While SCL is being pulsed, every low phase (`scl_pull_o`=1) and every high phase lasts exactly d system clocks, where d is the captured value.
- R3: `sda_pull_o` stays 0 during every clock pulse. It is never 1 in a cycle where `scl_pull_o` is 1.
- R4: The data line is judged in the last clock of each high phase. It counts as released only when `sda_in_i`=1 and `scl_in_i`=1 in that cycle. A held-low SCL line therefore counts as "data still low".
- R5: When the data line counts as released, SCL stays released and `sda_pull_o` goes to 1 for d clocks, which forms the START. Then `done_o` is 1 for exactly one cycle, with `sda_pull_o`=1 and `scl_pull_o`=0. In the following cycle both lines are released. With p pulses issued, `done_o` is visible d·(2p+1) clocks after the first low phase is visible.
- R6: At most MAX_PULSES (default 9) SCL pulses are issued. If the data line is still low at the end of the last high phase, `fail_o` is 1 for one cycle. In that cycle both lines are released. No START is issued: `sda_pull_o` never becomes 1 during that attempt. `fail_o` is visible 2·MAX_PULSES·d clocks after the first low phase is visible.
- R7: A start strobe that arrives while a recovery is running is ignored. A new `div_i` offered with it does not change the phase lengths or the completion time.
- R8: `sda_pull_o` never goes from 1 to 0 except in the cycle after `done_o`. The sequencer therefore cannot form a STOP before its START completes.
- R9: A captured divider value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe that begins a recovery |
| div_i | input | DIV_W | System clocks per SCL phase, captured at start |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in_i | input | 1 | Sampled level of the SDA line |
| scl_in_i | input | 1 | Sampled level of the SCL line |
| done_o | output | 1 | One-cycle pulse: START formed, bus handed over |
| fail_o | output | 1 | One-cycle pulse: pulse budget used up with SDA still low |

## Verification
The bench models a slave that lets go of SDA during the low phase of a chosen pulse. It tries a line that is already free, a release part-way through the budget, a release exactly on the last pulse and a slave that never lets go. A design that counts the budget one off either gives up one pulse early on the last-pulse release or issues a tenth pulse. A design that judges SDA without looking at SCL reports success while another device holds SCL low. Checking the completion time and the length of every low phase exposes a divider that is not captured, or one that is re-captured by a start strobe arriving mid-run. Watching SDA against SCL in every cycle catches a sequencer that lowers SDA during a pulse or forms a STOP before its START.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_START = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAIL  = 3'd5
  } rec_state_e;

  // Clocks per SCL phase for a given divider request; zero is lifted to one.
  function automatic int unsigned phase_clocks(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // Clocks from the first visible low phase to the done pulse, for p pulses.
  function automatic int unsigned done_latency(input int unsigned p, input int unsigned d);
    return d * (2 * p + 1);
  endfunction

endpackage

// File: rtl/busrec_phase_timer.sv
module busrec_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] len,
  output logic             last
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // len is never zero: the controller normalises it on capture
  assign last = (cnt == (len - 1'b1));

endmodule

// File: rtl/busrec_pulse_cnt.sv
module busrec_pulse_cnt #(
  parameter  int MAX_PULSES = 9,
  localparam int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_max
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && !at_max)    cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == CW'(MAX_PULSES));

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sda_in_i,
  input  logic             scl_in_i,
  input  logic             phase_last,
  input  logic             at_max,
  output logic             timer_clr,
  output logic             pulse_inc,
  output logic             pulse_clr,
  output logic [DIV_W-1:0] div_q,
  output logic             sample_ev,
  output logic             line_high,
  output logic             busy,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             done_o,
  output logic             fail_o
);

  rec_state_e state, nxt;

  assign line_high = sda_in_i & scl_in_i;
  assign sample_ev = (state == ST_HIGH) & phase_last;

  always_comb begin
    nxt       = state;
    timer_clr = 1'b0;
    pulse_inc = 1'b0;
    pulse_clr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        timer_clr = 1'b1;
        if (start_i) begin
          nxt       = ST_LOW;
          pulse_clr = 1'b1;
        end
      end
      ST_LOW: begin
        if (phase_last) begin
          nxt       = ST_HIGH;
          timer_clr = 1'b1;
          pulse_inc = 1'b1;
        end
      end
      ST_HIGH: begin
        if (phase_last) begin
          timer_clr = 1'b1;
          if (line_high)   nxt = ST_START;
          else if (at_max) nxt = ST_FAIL;
          else             nxt = ST_LOW;
        end
      end
      ST_START: begin
        if (phase_last) begin
          nxt       = ST_DONE;
          timer_clr = 1'b1;
        end
      end
      ST_DONE: begin
        nxt       = ST_IDLE;
        timer_clr = 1'b1;
      end
      ST_FAIL: begin
        nxt       = ST_IDLE;
        timer_clr = 1'b1;
      end
      default: begin
        nxt       = ST_IDLE;
        timer_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      div_q <= DIV_W'(1);
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start_i)
        div_q <= DIV_W'(phase_clocks(int'(div_i)));
    end
  end

  assign busy       = (state != ST_IDLE);
  assign scl_pull_o = (state == ST_LOW);
  assign sda_pull_o = (state == ST_START) | (state == ST_DONE);
  assign done_o     = (state == ST_DONE);
  assign fail_o     = (state == ST_FAIL);

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq #(
  parameter  int DIV_W      = 8,
  parameter  int MAX_PULSES = 9,
  localparam int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  input  logic             sda_in_i,
  input  logic             scl_in_i,
  output logic             done_o,
  output logic             fail_o
);

  logic             timer_clr;
  logic             phase_last;
  logic             pulse_inc;
  logic             pulse_clr;
  logic             at_max;
  logic [CW-1:0]    pulse_cnt;
  logic [DIV_W-1:0] div_q;
  logic             sample_ev;
  logic             line_high;
  logic             busy;

  busrec_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .div_i      (div_i),
    .sda_in_i   (sda_in_i),
    .scl_in_i   (scl_in_i),
    .phase_last (phase_last),
    .at_max     (at_max),
    .timer_clr  (timer_clr),
    .pulse_inc  (pulse_inc),
    .pulse_clr  (pulse_clr),
    .div_q      (div_q),
    .sample_ev  (sample_ev),
    .line_high  (line_high),
    .busy       (busy),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  busrec_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .len   (div_q),
    .last  (phase_last)
  );

  busrec_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pulse_clr),
    .inc    (pulse_inc),
    .cnt    (pulse_cnt),
    .at_max (at_max)
  );

endmodule

// File: rtl/busrec_chk.sv
module busrec_chk #(
  parameter  int DIV_W      = 8,
  parameter  int MAX_PULSES = 9,
  localparam int CW         = $clog2(MAX_PULSES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_pull_o,
  input logic             sda_pull_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             busy,
  input logic             sample_ev,
  input logic             line_high,
  input logic [CW-1:0]    pulse_cnt,
  input logic [DIV_W-1:0] div_q
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull_o && !sda_pull_o && !done_o && !fail_o));

  // R3
  sda_free_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> !sda_pull_o);

  // R4
  start_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(sample_ev && line_high));

  // R5
  done_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sda_pull_o && !scl_pull_o));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy));

  // R6
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(MAX_PULSES));

  // R6
  fail_at_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (pulse_cnt == CW'(MAX_PULSES) && !sda_pull_o && !scl_pull_o));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  // R8
  no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(done_o));

endmodule

bind busrec_seq busrec_chk #(.DIV_W(DIV_W), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .busy       (busy),
  .sample_ev  (sample_ev),
  .line_high  (line_high),
  .pulse_cnt  (pulse_cnt),
  .div_q      (div_q)
);

// File: tb/busrec_seq_tb.sv
module busrec_seq_tb;

  localparam int DIV_W  = 8;
  localparam int BUDGET = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic             scl_pull_o, sda_pull_o, done_o, fail_o;
  logic             slave_hold = 1'b0;
  logic             scl_hold = 1'b0;
  logic             sda_in_i, scl_in_i;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // open-drain line model: low if anyone pulls
  assign sda_in_i = !sda_pull_o && !slave_hold;
  assign scl_in_i = !scl_pull_o && !scl_hold;

  busrec_seq #(.DIV_W(DIV_W), .MAX_PULSES(BUDGET)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .div_i      (div_i),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .sda_in_i   (sda_in_i),
    .scl_in_i   (scl_in_i),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Result record of one recovery run
  int  r_pulses, r_n, r_badlen;
  bit  r_done, r_fail, r_sda_in_pulse, r_early_rise, r_sda_seen, r_after_ok;

  // rel: pulse in whose low phase the slave lets go (0 = free from the start,
  // large = never). extra: offer a second start strobe mid-run with div 7.
  task automatic run(input int div, input int rel, input bit sclh, input bit extra);
    int  d, run_len, rel_cnt;
    bit  prev_scl, prev_sda;
    d = (div == 0) ? 1 : div;
    r_pulses = 0; r_n = 0; r_badlen = 0; r_done = 0; r_fail = 0;
    r_sda_in_pulse = 0; r_early_rise = 0; r_sda_seen = 0; r_after_ok = 0;
    run_len = 0; rel_cnt = 0; prev_scl = 0; prev_sda = 0;
    slave_hold = (rel != 0);
    scl_hold = sclh;
    @(negedge clk);
    start_i = 1'b1; div_i = DIV_W'(div);
    @(negedge clk);
    start_i = 1'b0; div_i = 8'd5;
    while (r_n < 2000) begin
      if (scl_pull_o && !prev_scl) begin
        rel_cnt++;
        if (rel_cnt >= rel) slave_hold = 1'b0;
      end
      if (scl_pull_o) run_len++;
      else if (prev_scl) begin
        r_pulses++;
        if (run_len != d) r_badlen++;
        run_len = 0;
      end
      if (sda_pull_o && scl_pull_o) r_sda_in_pulse = 1;
      if (sda_pull_o) r_sda_seen = 1;
      if (sda_pull_o && !prev_sda && (scl_pull_o || !scl_in_i)) r_early_rise = 1;
      if (done_o) begin r_done = 1; break; end
      if (fail_o) begin r_fail = 1; break; end
      prev_scl = scl_pull_o; prev_sda = sda_pull_o;
      if (extra && r_n == 4) begin start_i = 1'b1; div_i = 8'd7; end
      @(negedge clk);
      start_i = 1'b0;
      r_n++;
    end
    @(negedge clk);
    r_after_ok = !scl_pull_o && !sda_pull_o && !done_o && !fail_o;
    scl_hold = 1'b0;
    slave_hold = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scl_pull_o && !sda_pull_o, "R1", "lines released in reset", {scl_pull_o, sda_pull_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scl_pull_o && !sda_pull_o && !done_o && !fail_o, "R1", "idle outputs after reset",
        {scl_pull_o, sda_pull_o, done_o, fail_o}, 0);
  endtask

  task automatic t_success(input int div, input int rel, input string tag);
    int d, p;
    d = (div == 0) ? 1 : div;
    p = (rel < 1) ? 1 : rel;
    run(div, rel, 1'b0, 1'b0);
    chk(r_done && !r_fail, "R5", {tag, " done reached"}, r_done, 1);
    chk(r_pulses == p, "R6", {tag, " pulse count"}, r_pulses, p);
    chk(r_n == d * (2 * p + 1), "R5", {tag, " done latency"}, r_n, d * (2 * p + 1));
    chk(r_badlen == 0, "R2", {tag, " low phase length"}, r_badlen, 0);
    chk(!r_sda_in_pulse, "R3", {tag, " SDA free during pulses"}, r_sda_in_pulse, 0);
    chk(!r_early_rise, "R8", {tag, " START formed with SCL high"}, r_early_rise, 0);
    chk(r_after_ok, "R5", {tag, " lines released after done"}, r_after_ok, 1);
  endtask

  task automatic t_stuck(input int div);
    run(div, 1000, 1'b0, 1'b0);
    chk(r_fail && !r_done, "R6", "stuck slave gives fail", r_fail, 1);
    chk(r_pulses == BUDGET, "R6", "stuck slave pulse count", r_pulses, BUDGET);
    chk(r_n == 2 * BUDGET * div, "R6", "fail latency", r_n, 2 * BUDGET * div);
    chk(!r_sda_seen, "R6", "no START on failure", r_sda_seen, 0);
    chk(r_after_ok, "R1", "idle after fail", r_after_ok, 1);
  endtask

  task automatic t_scl_held;
    run(2, 0, 1'b1, 1'b0);
    chk(r_fail && !r_done, "R4", "SCL held low counts as data low", r_fail, 1);
    chk(!r_sda_seen, "R4", "no START while SCL held", r_sda_seen, 0);
  endtask

  task automatic t_ignore_start;
    run(3, 4, 1'b0, 1'b1);
    chk(r_done, "R7", "mid-run strobe does not disturb", r_done, 1);
    chk(r_badlen == 0, "R7", "phase length kept after mid-run strobe", r_badlen, 0);
    chk(r_n == 3 * (2 * 4 + 1), "R7", "latency kept after mid-run strobe", r_n, 27);
  endtask

  initial begin
    t_reset();
    t_success(3, 0, "free line");
    t_success(2, 4, "release at pulse 4");
    t_success(1, BUDGET, "release at last pulse");
    t_success(0, 2, "R9 zero divider");
    t_success(5, 1, "release at pulse 1");
    t_stuck(2);
    t_scl_held();
    t_ignore_start();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule